// File: doc/BRIEF.md
# Bidirectional Byte-Status Mailbox Unit

This block passes small messages between two agents that share one clock: a host-side register port and a local-side register port. It holds two 32-bit mailboxes. The host writes into one and the local side reads it. The local side writes into the other and the host reads it. Every byte of each mailbox carries its own full flag. An 8-bit or 16-bit agent can therefore hand over a single byte without building a whole word. Both ports read the same status word, which holds all eight flags.

Each side has a small control register. It enables an interrupt toward that side and picks which byte of the incoming mailbox raises it. The interrupt is a level. It stays up until the receiving side clears it with a write-one-to-clear. Local hardware can also fill the whole local-to-host mailbox through a data port with a single load strobe, without a register cycle.

Each port has four word registers, chosen by a 2-bit address:
- 0: mailbox data.
- 1: status.
- 2: interrupt control.
- 3: interrupt status.

Read data is combinational and is valid in the same cycle as the read strobe. Writes and flag changes take effect at the next rising clock edge.

Top module: `mbox_pair_top`

## Requirements
- R1: A port write to address 0 stores the bytes whose byte enable is 1 (lane i is bits 8i+7..8i) into that side's outbound mailbox. Bytes whose enable is 0 keep their data.
- R2: Each byte written by R1 has its full flag set at the next edge. The status word (address 1) holds the host-to-local flags in bits 3..0 and the local-to-host flags in bits 7..4. All other bits read 0.
- R3: A port read of address 0 returns the whole inbound mailbox in the same cycle. It clears the full flag of exactly the bytes whose read byte enable is 1.
- R4: When a write and a read hit the same byte in the same cycle, the flag stays set. The new data is stored, and the read returns the old data.
- R5: Writing a byte that is already full replaces its data and leaves its flag set. No error is reported.
- R6: A hardware load strobe stores the hardware data word in all four bytes of the local-to-host mailbox and sets their four flags. It takes precedence over a local register write in the same cycle.
- R7: Interrupt control (address 2) holds an enable in bit 0 and a byte select in bits 2..1, and reads back the same way.
  - When enabled, a write to the selected byte of the mailbox inbound to that side sets that side's interrupt at the next edge. This covers a register write or a hardware load.
- R8: The interrupt is a level, shown in bit 0 of address 3. It stays set until that side writes 1 to bit 0 with byte enable 0 set.
  - Clearing it leaves the mailbox flags unchanged.
  - A set and a clear in the same cycle leave it set.
- R9: Reset clears all mailbox data, all flags, all enables, selects and interrupts. A port's read data is 0 whenever its read strobe is low.
- R10: The status word reads the same from both ports.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both ports |
| rst_n | input | 1 | Active-low synchronous reset |
| h_wr | input | 1 | Host write strobe |
| h_rd | input | 1 | Host read strobe |
| h_addr | input | 2 | Host register address |
| h_be | input | 4 | Host byte enables |
| h_wdata | input | 32 | Host write data |
| h_rdata | output | 32 | Host read data |
| l_wr | input | 1 | Local write strobe |
| l_rd | input | 1 | Local read strobe |
| l_addr | input | 2 | Local register address |
| l_be | input | 4 | Local byte enables |
| l_wdata | input | 32 | Local write data |
| l_rdata | output | 32 | Local read data |
| hw_load | input | 1 | Hardware load strobe for the local-to-host mailbox |
| hw_data | input | 32 | Hardware load data |
| host_irq | output | 1 | Interrupt toward the host side |
| local_irq | output | 1 | Interrupt toward the local side |

## Verification
The properties assume that every strobe is a clean 0 or 1 on each rising edge. They also assume that a read or write lasts exactly one cycle. Any cycle with a strobe high is taken as a fresh access, and repeated reads are allowed.

The stimulus keeps to these assumptions. All inputs change only on the falling edge, and every access is issued as a single-cycle step. The random phase draws addresses and byte enables freely, so simultaneous writes and reads, overwrites of full bytes, and load strobes meeting local writes all occur without ever holding a strobe across edges.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
    localparam logic [1:0] ADR_MBOX = 2'd0;
    localparam logic [1:0] ADR_STAT = 2'd1;
    localparam logic [1:0] ADR_CTRL = 2'd2;
    localparam logic [1:0] ADR_ISTS = 2'd3;
endpackage

// File: rtl/mbx_port_dec.sv
module mbx_port_dec
    import mbx_pkg::*;
#(
    parameter int NB = 4,
    localparam int DW = 8 * NB,
    localparam int SW = $clog2(NB)
) (
    input  logic            wr,
    input  logic            rd,
    input  logic [1:0]      addr,
    input  logic [NB-1:0]   be,
    input  logic [DW-1:0]   wdata,
    input  logic [DW-1:0]   in_data,
    input  logic [2*NB-1:0] status,
    input  logic            cfg_en,
    input  logic [SW-1:0]   cfg_sel,
    input  logic            pend,
    output logic [NB-1:0]   wr_be,
    output logic [NB-1:0]   rd_be,
    output logic            cfg_we,
    output logic            clr_req,
    output logic [DW-1:0]   rdata
);
    always_comb begin
        wr_be   = (wr && addr == ADR_MBOX) ? be : '0;
        rd_be   = (rd && addr == ADR_MBOX) ? be : '0;
        cfg_we  = wr && addr == ADR_CTRL && be[0];
        clr_req = wr && addr == ADR_ISTS && be[0] && wdata[0];
        rdata   = '0;
        if (rd) begin
            case (addr)
                ADR_MBOX: rdata = in_data;
                ADR_STAT: rdata[2*NB-1:0] = status;
                ADR_CTRL: rdata[SW:0] = {cfg_sel, cfg_en};
                default:  rdata[0] = pend;
            endcase
        end
    end
endmodule

// File: rtl/mbx_lane.sv
module mbx_lane #(
    parameter int NB = 4,
    localparam int DW = 8 * NB
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NB-1:0] wr_be,
    input  logic [DW-1:0] wdata,
    input  logic          hw_load,
    input  logic [DW-1:0] hw_data,
    input  logic [NB-1:0] rd_be,
    output logic [DW-1:0] data,
    output logic [NB-1:0] full,
    output logic [NB-1:0] byte_hit
);
    typedef struct packed {
        logic [NB-1:0][7:0] data;
        logic [NB-1:0]      full;
    } lane_t;

    lane_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        byte_hit = '0;
        for (int i = 0; i < NB; i++) begin
            if (hw_load) begin
                st_d.data[i] = hw_data[8*i +: 8];
                st_d.full[i] = 1'b1;
                byte_hit[i]  = 1'b1;
            end else if (wr_be[i]) begin
                st_d.data[i] = wdata[8*i +: 8];
                st_d.full[i] = 1'b1;
                byte_hit[i]  = 1'b1;
            end else if (rd_be[i]) begin
                st_d.full[i] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign data = st_q.data;
    assign full = st_q.full;
endmodule

// File: rtl/mbx_irq.sv
module mbx_irq #(
    parameter int NB = 4,
    localparam int SW = $clog2(NB)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [SW:0]   cfg_wdata,
    input  logic          clr_req,
    input  logic [NB-1:0] byte_hit,
    output logic          en,
    output logic [SW-1:0] sel,
    output logic          pend
);
    typedef struct packed {
        logic          en;
        logic [SW-1:0] sel;
        logic          pend;
    } irq_t;

    irq_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cfg_we) begin
            st_d.en  = cfg_wdata[0];
            st_d.sel = cfg_wdata[SW:1];
        end
        st_d.pend = (st_q.en && byte_hit[st_q.sel]) || (st_q.pend && !clr_req);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign en   = st_q.en;
    assign sel  = st_q.sel;
    assign pend = st_q.pend;
endmodule

// File: rtl/mbox_pair_top.sv
module mbox_pair_top #(
    parameter int NB = 4,
    localparam int DW = 8 * NB,
    localparam int SW = $clog2(NB)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          h_wr,
    input  logic          h_rd,
    input  logic [1:0]    h_addr,
    input  logic [NB-1:0] h_be,
    input  logic [DW-1:0] h_wdata,
    output logic [DW-1:0] h_rdata,
    input  logic          l_wr,
    input  logic          l_rd,
    input  logic [1:0]    l_addr,
    input  logic [NB-1:0] l_be,
    input  logic [DW-1:0] l_wdata,
    output logic [DW-1:0] l_rdata,
    input  logic          hw_load,
    input  logic [DW-1:0] hw_data,
    output logic          host_irq,
    output logic          local_irq
);
    logic [DW-1:0]   h2l_data, l2h_data;
    logic [NB-1:0]   h2l_full, l2h_full;
    logic [NB-1:0]   h2l_hit, l2h_hit;
    logic [NB-1:0]   h_wr_be, h_rd_be, l_wr_be, l_rd_be;
    logic            h_cfg_we, h_clr, l_cfg_we, l_clr;
    logic            h_en, l_en;
    logic [SW-1:0]   h_sel, l_sel;
    logic [2*NB-1:0] status;

    assign status = {l2h_full, h2l_full};

    mbx_port_dec #(.NB(NB)) u_hdec (
        .wr(h_wr), .rd(h_rd), .addr(h_addr), .be(h_be), .wdata(h_wdata),
        .in_data(l2h_data), .status(status), .cfg_en(h_en), .cfg_sel(h_sel),
        .pend(host_irq), .wr_be(h_wr_be), .rd_be(h_rd_be), .cfg_we(h_cfg_we),
        .clr_req(h_clr), .rdata(h_rdata)
    );

    mbx_port_dec #(.NB(NB)) u_ldec (
        .wr(l_wr), .rd(l_rd), .addr(l_addr), .be(l_be), .wdata(l_wdata),
        .in_data(h2l_data), .status(status), .cfg_en(l_en), .cfg_sel(l_sel),
        .pend(local_irq), .wr_be(l_wr_be), .rd_be(l_rd_be), .cfg_we(l_cfg_we),
        .clr_req(l_clr), .rdata(l_rdata)
    );

    mbx_lane #(.NB(NB)) u_h2l (
        .clk(clk), .rst_n(rst_n), .wr_be(h_wr_be), .wdata(h_wdata),
        .hw_load(1'b0), .hw_data('0), .rd_be(l_rd_be),
        .data(h2l_data), .full(h2l_full), .byte_hit(h2l_hit)
    );

    mbx_lane #(.NB(NB)) u_l2h (
        .clk(clk), .rst_n(rst_n), .wr_be(l_wr_be), .wdata(l_wdata),
        .hw_load(hw_load), .hw_data(hw_data), .rd_be(h_rd_be),
        .data(l2h_data), .full(l2h_full), .byte_hit(l2h_hit)
    );

    mbx_irq #(.NB(NB)) u_hirq (
        .clk(clk), .rst_n(rst_n), .cfg_we(h_cfg_we), .cfg_wdata(h_wdata[SW:0]),
        .clr_req(h_clr), .byte_hit(l2h_hit), .en(h_en), .sel(h_sel), .pend(host_irq)
    );

    mbx_irq #(.NB(NB)) u_lirq (
        .clk(clk), .rst_n(rst_n), .cfg_we(l_cfg_we), .cfg_wdata(l_wdata[SW:0]),
        .clr_req(l_clr), .byte_hit(h2l_hit), .en(l_en), .sel(l_sel), .pend(local_irq)
    );
endmodule

// File: rtl/mbx_checker.sv
module mbx_checker
    import mbx_pkg::*;
#(
    parameter int NB = 4,
    localparam int DW = 8 * NB
) (
    input logic          clk,
    input logic          rst_n,
    input logic          h_wr,
    input logic          h_rd,
    input logic [1:0]    h_addr,
    input logic [NB-1:0] h_be,
    input logic [DW-1:0] h_wdata,
    input logic          l_wr,
    input logic          l_rd,
    input logic [1:0]    l_addr,
    input logic [NB-1:0] l_be,
    input logic [DW-1:0] l_wdata,
    input logic          hw_load,
    input logic [DW-1:0] hw_data,
    input logic          host_irq,
    input logic          local_irq,
    input logic [DW-1:0] h2l_data,
    input logic [DW-1:0] l2h_data,
    input logic [NB-1:0] h2l_full,
    input logic [NB-1:0] l2h_full
);
    logic h_mb_wr, h_mb_rd, l_mb_wr, l_mb_rd, h_clr, l_clr;
    assign h_mb_wr = h_wr && h_addr == ADR_MBOX;
    assign h_mb_rd = h_rd && h_addr == ADR_MBOX;
    assign l_mb_wr = l_wr && l_addr == ADR_MBOX;
    assign l_mb_rd = l_rd && l_addr == ADR_MBOX;
    assign h_clr   = h_wr && h_addr == ADR_ISTS && h_be[0] && h_wdata[0];
    assign l_clr   = l_wr && l_addr == ADR_ISTS && l_be[0] && l_wdata[0];

    for (genvar i = 0; i < NB; i++) begin : g_byte
        AST_H2L_DATA: assert property (@(posedge clk) disable iff (!rst_n)
            h_mb_wr && h_be[i] |=> h2l_data[8*i +: 8] == $past(h_wdata[8*i +: 8])); // R1
        AST_H2L_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
            !(h_mb_wr && h_be[i]) |=> $stable(h2l_data[8*i +: 8])); // R1
        AST_H2L_SET: assert property (@(posedge clk) disable iff (!rst_n)
            h_mb_wr && h_be[i] |=> h2l_full[i]); // R2
        AST_H2L_CLR: assert property (@(posedge clk) disable iff (!rst_n)
            l_mb_rd && l_be[i] && !(h_mb_wr && h_be[i]) |=> !h2l_full[i]); // R3
        AST_L2H_CLR: assert property (@(posedge clk) disable iff (!rst_n)
            h_mb_rd && h_be[i] && !hw_load && !(l_mb_wr && l_be[i]) |=> !l2h_full[i]); // R3
        AST_L2H_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
            !hw_load && !(l_mb_wr && l_be[i]) && !(h_mb_rd && h_be[i])
            |=> $stable(l2h_full[i])); // R8
    end

    AST_HW_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        hw_load |=> l2h_data == $past(hw_data) && &l2h_full); // R6
    AST_HIRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        host_irq && !h_clr |=> host_irq); // R8
    AST_LIRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        local_irq && !l_clr |=> local_irq); // R8
    AST_LIRQ_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        !local_irq && !h_mb_wr |=> !local_irq); // R7
endmodule

bind mbox_pair_top mbx_checker #(.NB(NB)) u_chk (.*);

// File: tb/tb_mbox_pair_top.sv
module tb_mbox_pair_top;
    localparam int CLK_PERIOD = 10;
    localparam int RAND_STEPS = 3000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        h_wr = 0, h_rd = 0, l_wr = 0, l_rd = 0, hw_load = 0;
    logic [1:0]  h_addr = 0, l_addr = 0;
    logic [3:0]  h_be = 0, l_be = 0;
    logic [31:0] h_wdata = 0, l_wdata = 0, hw_data = 0;
    logic [31:0] h_rdata, l_rdata;
    logic        host_irq, local_irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [31:0] m_h2l, m_l2h;
    logic [3:0]  f_h2l, f_l2h;
    logic        m_hen, m_len, m_hpend, m_lpend;
    logic [1:0]  m_hsel, m_lsel;

    mbox_pair_top dut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [31:0] exp_rd(input bit host, input logic rd, input logic [1:0] a);
        logic [31:0] r = '0;
        if (rd) begin
            case (a)
                2'd0: r = host ? m_l2h : m_h2l;
                2'd1: r[7:0] = {f_l2h, f_h2l};
                2'd2: r[2:0] = host ? {m_hsel, m_hen} : {m_lsel, m_len};
                default: r[0] = host ? m_hpend : m_lpend;
            endcase
        end
        return r;
    endfunction

    function automatic string tag_of(input string t, input logic rd, input logic [1:0] a);
        if (t != "") return t;
        if (!rd) return "R9";
        case (a)
            2'd0: return "R3";
            2'd1: return "R10";
            2'd2: return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic step(input string t,
                        input logic hwr, input logic hrd, input logic [1:0] ha, input logic [3:0] hb, input logic [31:0] hd,
                        input logic lwr, input logic lrd, input logic [1:0] la, input logic [3:0] lb, input logic [31:0] ld,
                        input logic hl, input logic [31:0] hwd);
        logic [3:0] hit_h2l, hit_l2h;
        logic sh, sl;
        @(negedge clk);
        h_wr = hwr; h_rd = hrd; h_addr = ha; h_be = hb; h_wdata = hd;
        l_wr = lwr; l_rd = lrd; l_addr = la; l_be = lb; l_wdata = ld;
        hw_load = hl; hw_data = hwd;
        #1;
        check(tag_of(t, hrd, ha), "host rdata", h_rdata, exp_rd(1'b1, hrd, ha));
        check(tag_of(t, lrd, la), "local rdata", l_rdata, exp_rd(1'b0, lrd, la));
        @(posedge clk);
        hit_h2l = '0; hit_l2h = '0;
        for (int i = 0; i < 4; i++) begin
            if (hwr && ha == 2'd0 && hb[i]) begin
                m_h2l[8*i +: 8] = hd[8*i +: 8]; f_h2l[i] = 1'b1; hit_h2l[i] = 1'b1;
            end else if (lrd && la == 2'd0 && lb[i]) f_h2l[i] = 1'b0;
            if (hl) begin
                m_l2h[8*i +: 8] = hwd[8*i +: 8]; f_l2h[i] = 1'b1; hit_l2h[i] = 1'b1;
            end else if (lwr && la == 2'd0 && lb[i]) begin
                m_l2h[8*i +: 8] = ld[8*i +: 8]; f_l2h[i] = 1'b1; hit_l2h[i] = 1'b1;
            end else if (hrd && ha == 2'd0 && hb[i]) f_l2h[i] = 1'b0;
        end
        sh = m_hen && hit_l2h[m_hsel];
        sl = m_len && hit_h2l[m_lsel];
        m_hpend = sh || (m_hpend && !(hwr && ha == 2'd3 && hb[0] && hd[0]));
        m_lpend = sl || (m_lpend && !(lwr && la == 2'd3 && lb[0] && ld[0]));
        if (hwr && ha == 2'd2 && hb[0]) begin m_hen = hd[0]; m_hsel = hd[2:1]; end
        if (lwr && la == 2'd2 && lb[0]) begin m_len = ld[0]; m_lsel = ld[2:1]; end
        #1;
        check((t != "") ? t : "R7", "host_irq", {31'b0, host_irq}, {31'b0, m_hpend});
        check((t != "") ? t : "R7", "local_irq", {31'b0, local_irq}, {31'b0, m_lpend});
    endtask

    task automatic hop(input string t, input logic wr, input logic rd, input logic [1:0] a, input logic [3:0] b, input logic [31:0] d);
        step(t, wr, rd, a, b, d, 0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic lop(input string t, input logic wr, input logic rd, input logic [1:0] a, input logic [3:0] b, input logic [31:0] d);
        step(t, 0, 0, 0, 0, 0, wr, rd, a, b, d, 0, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        m_h2l = 0; m_l2h = 0; f_h2l = 0; f_l2h = 0;
        m_hen = 0; m_len = 0; m_hpend = 0; m_lpend = 0; m_hsel = 0; m_lsel = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R9: reset state, idle read data
        step("R9", 0, 0, 0, 4'hF, 32'hFFFF_FFFF, 0, 0, 0, 4'hF, 32'hFFFF_FFFF, 0, 0);
        hop("R9", 0, 1, 2'd1, 4'hF, 0);
        lop("R9", 0, 1, 2'd2, 4'hF, 0);
        lop("R9", 0, 1, 2'd0, 4'h0, 0);
        // R1/R2: single byte lane write, status layout
        hop("R1", 1, 0, 2'd0, 4'b0010, 32'hAABB_CCDD);
        lop("R2", 0, 1, 2'd1, 4'hF, 0);
        hop("R10", 0, 1, 2'd1, 4'hF, 0);
        // R3: read with partial enables clears only those bytes
        hop("R1", 1, 0, 2'd0, 4'b1001, 32'h1122_3344);
        lop("R3", 0, 1, 2'd0, 4'b0010, 0);
        lop("R3", 0, 1, 2'd1, 4'hF, 0);
        // R5: overwrite full byte
        hop("R5", 1, 0, 2'd0, 4'b0001, 32'h0000_0055);
        lop("R5", 0, 1, 2'd0, 4'b0000, 0);
        lop("R5", 0, 1, 2'd1, 4'hF, 0);
        // R4: same-cycle write and read of one byte
        step("R4", 1, 0, 2'd0, 4'b0100, 32'h0077_0000, 0, 1, 2'd0, 4'b0100, 0, 0, 0);
        lop("R4", 0, 1, 2'd1, 4'hF, 0);
        lop("R4", 0, 1, 2'd0, 4'b1111, 0);
        // R7: local interrupt on byte 2
        lop("R7", 1, 0, 2'd2, 4'b0001, 32'h0000_0005);
        lop("R7", 0, 1, 2'd2, 4'hF, 0);
        hop("R7", 1, 0, 2'd0, 4'b0010, 32'h0000_9900);
        hop("R7", 1, 0, 2'd0, 4'b0100, 32'h0042_0000);
        lop("R7", 0, 1, 2'd3, 4'hF, 0);
        // R8: clear keeps flags
        lop("R8", 1, 0, 2'd3, 4'b0001, 32'h1);
        lop("R8", 0, 1, 2'd1, 4'hF, 0);
        // R6: hw load beats local write, raises host irq on byte 3
        hop("R7", 1, 0, 2'd2, 4'b0001, 32'h0000_0007);
        step("R6", 0, 0, 0, 0, 0, 1, 0, 2'd0, 4'hF, 32'hDEAD_BEEF, 1, 32'hCAFE_F00D);
        hop("R6", 0, 1, 2'd0, 4'b0000, 0);
        hop("R6", 0, 1, 2'd1, 4'hF, 0);
        // R8: set and clear together keep the interrupt
        step("R8", 1, 0, 2'd3, 4'b0001, 32'h1, 0, 0, 0, 0, 0, 1, 32'h0102_0304);
        hop("R8", 0, 1, 2'd3, 4'hF, 0);
        hop("R8", 1, 0, 2'd3, 4'b0001, 32'h1);
        hop("R10", 0, 1, 2'd0, 4'hF, 0);
        lop("R10", 0, 1, 2'd1, 4'hF, 0);

        for (int n = 0; n < RAND_STEPS; n++) begin
            logic [1:0] ha, la;
            ha = 2'($urandom_range(0, 3));
            la = 2'($urandom_range(0, 3));
            if ($urandom_range(0, 2) != 0) ha = 2'd0;
            if ($urandom_range(0, 2) != 0) la = 2'd0;
            step("", 1'($urandom), 1'($urandom), ha, 4'($urandom), $urandom,
                 1'($urandom), 1'($urandom), la, 4'($urandom), $urandom,
                 ($urandom_range(0, 9) == 0), $urandom);
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule